// File: doc/BRIEF.md
# Cache way lending controller

This block sits next to the tag directory of a set-associative last-level cache. It can take one cache way out of caching service, lend it to a compute engine, and later return it. An allocate command names a way. The controller then walks that way through every set index, addressing each line by its (way, set) pair and never by memory address. Dirty lines are written back before they are invalidated. Clean lines are invalidated at once, and empty lines are skipped.

When the last set has been handled, the way's lending flag is raised and a one-cycle completion pulse is given. From then on the way is left out of both victim choice and hit detection. A release command clears the flag, and the way returns to service with every line invalid. The processor is never halted. Normal lookups own the shared directory port, and the walk only moves forward on cycles when that port is idle. Commands that would lend a way twice, overlap a walk, or leave no way in cache service are refused.

Top module: `way_lend_ctrl`

## Requirements
- R1: After an accepted allocate, `dir_req` presents `dir_way` equal to the target way and `dir_set` stepping 0,1,…,SETS-1 in order. `busy` is high from the cycle after acceptance until the completion pulse.
- R2: A directory entry that reads invalid costs one free port cycle and raises no `dir_inv`.
- R3: `dir_req` and `dir_inv` are only asserted in cycles where `cpu_req` is low.
- R4: A valid, clean entry (`dir_valid`=1, `dir_dirty`=0) is invalidated with `dir_inv` in the same cycle it is read.
- R5: A valid, dirty entry raises `wb_req` from the next cycle, carrying the read tag, the set and the way. These stay stable until `wb_ack`. The line is then invalidated on the next free port cycle.
- R6: In the cycle after the last set is processed, `done` pulses for one cycle and the target way's bit in `lend_mask` reads 1.
- R7: `hit_mask` is the inverse of `lend_mask`. `repl_mask` also clears the bit of the way being walked while `busy` is high.
- R8: Every command (`cmd_op`=0 allocate, `cmd_op`=1 release) gets `rsp_valid` for exactly one cycle, in the next cycle, with `rsp_err` giving the outcome.
- R9: An allocate is refused (`rsp_err`=1, no walk starts) when a walk is in progress or when the named way is already lent.
- R10: An allocate is refused when WAYS-1 ways are already lent. At least one way always stays in cache mode.
- R11: A release of a lent way clears its `lend_mask` bit from the next cycle. This is allowed while another way's walk is running. A release of a way that is not lent is refused and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 1 | 0 allocate, 1 release |
| cmd_way | input | WAY_W | Way named by the command |
| rsp_valid | output | 1 | Command response strobe |
| rsp_err | output | 1 | Command refused |
| done | output | 1 | Allocate walk complete |
| busy | output | 1 | Walk in progress |
| cpu_req | input | 1 | Processor lookup owns the directory port this cycle |
| dir_req | output | 1 | Walk reads the directory entry |
| dir_set | output | SET_W | Set index of the walk |
| dir_way | output | WAY_W | Way index of the walk |
| dir_valid | input | 1 | Entry valid (same-cycle response) |
| dir_dirty | input | 1 | Entry dirty (same-cycle response) |
| dir_tag | input | TAG_W | Entry tag (same-cycle response) |
| dir_inv | output | 1 | Invalidate the entry at dir_set/dir_way |
| wb_req | output | 1 | Writeback request |
| wb_tag | output | TAG_W | Writeback tag |
| wb_set | output | SET_W | Writeback set |
| wb_way | output | WAY_W | Writeback way |
| wb_ack | input | 1 | Writeback accepted |
| lend_mask | output | WAYS | Ways lent to compute |
| repl_mask | output | WAYS | Ways eligible as victims |
| hit_mask | output | WAYS | Ways eligible for hits |

## Verification
The bench builds the block with 4 ways, 8 sets and 8-bit tags. With these values the refusal that keeps one way in cache mode is reached after only three lends. The end of the set walk also comes up several times within a short run. Eight sets are enough to hold a mix of empty, clean and dirty lines in one walk. Alternating processor-busy patterns and a delayed writeback acknowledge cover both stall sources on every set.

// File: rtl/way_lend_ctrl.sv
module way_lend_ctrl #(
  parameter int WAYS  = 16,
  parameter int SETS  = 1024,
  parameter int TAG_W = 20,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic             cmd_op,
  input  logic [WAY_W-1:0] cmd_way,
  output logic             rsp_valid,
  output logic             rsp_err,
  output logic             done,
  output logic             busy,
  input  logic             cpu_req,
  output logic             dir_req,
  output logic [SET_W-1:0] dir_set,
  output logic [WAY_W-1:0] dir_way,
  input  logic             dir_valid,
  input  logic             dir_dirty,
  input  logic [TAG_W-1:0] dir_tag,
  output logic             dir_inv,
  output logic             wb_req,
  output logic [TAG_W-1:0] wb_tag,
  output logic [SET_W-1:0] wb_set,
  output logic [WAY_W-1:0] wb_way,
  input  logic             wb_ack,
  output logic [WAYS-1:0]  lend_mask,
  output logic [WAYS-1:0]  repl_mask,
  output logic [WAYS-1:0]  hit_mask
);

  typedef enum logic [1:0] {S_IDLE, S_WALK, S_WB, S_INV} st_t;

  st_t              st;
  logic [SET_W-1:0] set_q;
  logic [WAY_W-1:0] way_q;
  logic [TAG_W-1:0] tag_q;
  logic [WAYS-1:0]  flags;
  logic             done_q, rsp_v_q, rsp_e_q;

  logic free, dirty_hit, step, last, alloc_err, rel_err;
  logic [WAYS-1:0] walk_oh;

  assign free      = !cpu_req;
  assign dirty_hit = dir_valid && dir_dirty;
  assign busy      = st != S_IDLE;
  assign dir_req   = free && (st == S_WALK || st == S_INV);
  assign dir_set   = set_q;
  assign dir_way   = way_q;
  assign dir_inv   = free && ((st == S_WALK && dir_valid && !dir_dirty) || st == S_INV);
  assign step      = free && ((st == S_WALK && !dirty_hit) || st == S_INV);
  assign last      = set_q == SET_W'(SETS - 1);

  assign wb_req = st == S_WB;
  assign wb_tag = tag_q;
  assign wb_set = set_q;
  assign wb_way = way_q;

  assign alloc_err = busy || flags[cmd_way] || ($countones(flags) >= WAYS - 1);
  assign rel_err   = !flags[cmd_way];

  assign walk_oh   = busy ? (WAYS'(1) << way_q) : '0;
  assign lend_mask = flags;
  assign hit_mask  = ~flags;
  assign repl_mask = ~(flags | walk_oh);

  assign done      = done_q;
  assign rsp_valid = rsp_v_q;
  assign rsp_err   = rsp_e_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      set_q   <= '0;
      way_q   <= '0;
      tag_q   <= '0;
      flags   <= '0;
      done_q  <= 1'b0;
      rsp_v_q <= 1'b0;
      rsp_e_q <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      rsp_v_q <= cmd_valid;
      rsp_e_q <= cmd_valid && (cmd_op ? rel_err : alloc_err);
      if (cmd_valid && cmd_op && !rel_err) flags[cmd_way] <= 1'b0;
      case (st)
        S_IDLE: if (cmd_valid && !cmd_op && !alloc_err) begin
          st    <= S_WALK;
          way_q <= cmd_way;
          set_q <= '0;
        end
        S_WALK: if (free && dirty_hit) begin
          tag_q <= dir_tag;
          st    <= S_WB;
        end
        S_WB: if (wb_ack) st <= S_INV;
        default: ;
      endcase
      if (step) begin
        if (last) begin
          flags[way_q] <= 1'b1;
          done_q       <= 1'b1;
          st           <= S_IDLE;
        end else begin
          set_q <= set_q + 1'b1;
          st    <= S_WALK;
        end
      end
    end
  end

  a_r3_port_yield: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_req || dir_inv) |-> !cpu_req);

  a_r5_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req && !wb_ack) |=> (wb_req && $stable(wb_tag) && $stable(wb_set)));

  a_r6_done_lends: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lend_mask[way_q] && !busy));

  a_r10_one_cache_way: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lend_mask) < WAYS);

  a_r8_rsp_follows_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(cmd_valid));

  a_r7_walk_not_victim: assert property (@(posedge clk) disable iff (!rst_n)
    dir_req |-> !repl_mask[dir_way]);

endmodule

// File: tb/way_lend_ctrl_tb.sv
`timescale 1ns/100ps
module way_lend_ctrl_tb;
  localparam int WAYS = 4, SETS = 8, TAG_W = 8;
  localparam int WAY_W = 2, SET_W = 3;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_op = 0, cpu_req = 0, wb_ack = 0;
  logic [WAY_W-1:0] cmd_way = 0;
  logic rsp_valid, rsp_err, done, busy, dir_req, dir_inv, wb_req;
  logic [SET_W-1:0] dir_set, wb_set;
  logic [WAY_W-1:0] dir_way, wb_way;
  logic [TAG_W-1:0] wb_tag;
  logic [WAYS-1:0] lend_mask, repl_mask, hit_mask;

  logic dv [SETS][WAYS];
  logic dd [SETS][WAYS];
  logic [TAG_W-1:0] dt [SETS][WAYS];

  wire dir_valid = dv[dir_set][dir_way];
  wire dir_dirty = dd[dir_set][dir_way];
  wire [TAG_W-1:0] dir_tag = dt[dir_set][dir_way];

  always #2.5 clk = ~clk;

  way_lend_ctrl #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_way(cmd_way),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .done(done), .busy(busy), .cpu_req(cpu_req),
    .dir_req(dir_req), .dir_set(dir_set), .dir_way(dir_way), .dir_valid(dir_valid),
    .dir_dirty(dir_dirty), .dir_tag(dir_tag), .dir_inv(dir_inv), .wb_req(wb_req),
    .wb_tag(wb_tag), .wb_set(wb_set), .wb_way(wb_way), .wb_ack(wb_ack),
    .lend_mask(lend_mask), .repl_mask(repl_mask), .hit_mask(hit_mask));

  int checks = 0, fails = 0, cnt = 0, pat = 0, wbw = 0, wb_seen = 0;
  bit wd = 0;
  bit pc_v = 0, pc_op = 0;
  int pc_w = 0;
  bit mb = 0, mdone = 0, mrsp = 0, merr = 0;
  int mph = 0, ms = 0, mw = 0, mtag = 0;
  bit [WAYS-1:0] mflags = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cnt);
    end
  endtask

  task automatic cyc();
    bit e_req, e_inv, e_wb, v, d, nerr;
    bit [WAYS-1:0] e_repl;
    int t;
    @(negedge clk);
    cnt++;
    if (cnt > 20000 && !wd) begin
      wd = 1; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cnt, 20000);
    end
    cpu_req = (pat != 0) && (cnt % pat == 0);
    wb_ack = wb_req && (wbw >= 2);
    cmd_valid = pc_v; cmd_op = pc_op; cmd_way = WAY_W'(pc_w);
    pc_v = 0;
    #1;
    v = dv[ms][mw]; d = dd[ms][mw]; t = int'(dt[ms][mw]);
    e_req = mb && (mph == 0 || mph == 2) && !cpu_req;
    e_inv = e_req && (mph == 2 || (v && !d));
    e_wb = mb && mph == 1;
    e_repl = ~(mflags | (mb ? (WAYS'(1) << mw) : '0));
    chk(busy == mb, "R1 busy", busy, mb);
    chk(dir_req == e_req, "R3 dir_req", dir_req, e_req);
    if (e_req) chk(dir_set == SET_W'(ms) && dir_way == WAY_W'(mw), "R1 set/way", {dir_way, dir_set}, {mw[1:0], ms[2:0]});
    chk(dir_inv == e_inv, "R2/R4 dir_inv", dir_inv, e_inv);
    chk(wb_req == e_wb, "R5 wb_req", wb_req, e_wb);
    if (e_wb) chk(wb_tag == TAG_W'(mtag) && wb_set == SET_W'(ms) && wb_way == WAY_W'(mw), "R5 wb fields", {wb_way, wb_set, wb_tag}, {mw[1:0], ms[2:0], mtag[7:0]});
    chk(done == mdone, "R6 done", done, mdone);
    chk(lend_mask == mflags, "R6/R11 lend_mask", lend_mask, mflags);
    chk(hit_mask == ~mflags && repl_mask == e_repl, "R7 masks", {hit_mask, repl_mask}, {~mflags, e_repl});
    chk(rsp_valid == mrsp && (!mrsp || rsp_err == merr), "R8/R9/R10/R11 response", {rsp_valid, rsp_err}, {mrsp, merr});
    if (wb_req && wb_ack) wb_seen++;
    // model next state
    mdone = 0;
    mrsp = cmd_valid;
    nerr = 0;
    if (cmd_valid) begin
      if (cmd_op) begin
        nerr = !mflags[cmd_way];
        if (!nerr) mflags[cmd_way] = 0;
      end else begin
        nerr = mb || mflags[cmd_way] || ($countones(mflags) >= WAYS - 1);
      end
    end
    merr = nerr;
    if (mb) begin
      if ((mph == 0 && !cpu_req && !(v && d)) || (mph == 2 && !cpu_req)) begin
        if (ms == SETS - 1) begin mflags[mw] = 1; mdone = 1; mb = 0; end
        else begin ms++; mph = 0; end
      end else if (mph == 0 && !cpu_req) begin
        mtag = t; mph = 1;
      end else if (mph == 1 && wb_ack) begin
        mph = 2;
      end
    end else if (cmd_valid && !cmd_op && !nerr) begin
      mb = 1; mw = int'(cmd_way); ms = 0; mph = 0;
    end
    if (dir_inv) dv[dir_set][dir_way] = 0;
    wbw = (wb_req && !wb_ack) ? wbw + 1 : 0;
  endtask

  task automatic cmd(input bit op, input int w);
    pc_v = 1; pc_op = op; pc_w = w;
    cyc();
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n && !wd; i++) cyc();
  endtask

  function automatic bit way_clean(input int w);
    for (int s = 0; s < SETS; s++) if (dv[s][w]) return 0;
    return 1;
  endfunction

  initial begin
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        dv[s][w] = ((s + w) % 3) != 0;
        dd[s][w] = ((s * 5 + w) % 4) == 1;
        dt[s][w] = TAG_W'(s * 16 + w * 3 + 7);
      end
    for (int s = 0; s < SETS; s++) begin dv[s][2] = 1; dd[s][2] = 1; end
    repeat (3) @(negedge clk);
    #1;
    chk(lend_mask == 0 && !busy && !done && !rsp_valid && !wb_req && !dir_req, "R1 reset state", {lend_mask, busy}, 0);
    rst_n = 1;
    // mixed way, light processor load
    pat = 3;
    cmd(0, 1);
    run(5);
    cmd(0, 2);                      // R9: walk in progress
    run(60);
    chk(lend_mask == 4'b0010, "R6 way1 lent", lend_mask, 4'b0010);
    chk(way_clean(1), "R4/R5 way1 emptied", 0, 0);
    cmd(0, 1);                      // R9: already lent
    run(2);
    // all-dirty way, heavy processor load
    pat = 2;
    wb_seen = 0;
    cmd(0, 2);
    run(120);
    chk(wb_seen == SETS, "R5 writebacks for way2", wb_seen, SETS);
    chk(way_clean(2), "R5 way2 emptied", 0, 0);
    // third lend allowed, fourth refused
    pat = 0;
    cmd(0, 3);
    run(40);
    chk(lend_mask == 4'b1110, "R10 three lent", lend_mask, 4'b1110);
    cmd(0, 0);                      // R10: last cache way
    run(2);
    chk(lend_mask == 4'b1110 && !busy, "R10 refused no walk", {lend_mask, busy}, 5'b11100);
    cmd(1, 0);                      // R11: not lent
    run(2);
    cmd(1, 2);                      // R11: release
    run(2);
    chk(lend_mask == 4'b1010 && hit_mask == 4'b0101, "R11 released way2", lend_mask, 4'b1010);
    // release during another walk
    pat = 4;
    cmd(0, 2);
    run(3);
    cmd(1, 1);
    run(40);
    chk(lend_mask == 4'b1100, "R11 release during walk", lend_mask, 4'b1100);
    run(4);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule